// File: doc/BRIEF.md
# Data Address Translation Unit

This block turns a 43-bit data virtual address into a 44-bit physical address for loads and stores. It works with 8 KB pages. The TLB itself lives outside the block, and so does miss handling. The block receives the outcome of a TLB lookup: a hit flag, the page frame number, per-mode read and write enables, and the fault-on-read and fault-on-write bits. From these and the request attributes it decides, in the same cycle, the physical address, whether that address is uncacheable, and which fault, if any, is raised.

Three request kinds bypass the TLB:
- A physical-mode request passes the address straight through.
- A kernel-region superpage access maps the virtual address directly onto physical space.
- Privileged code, when it asks for it, takes its permission mode from an alternate mode input.

When a recoverable fault occurs, the block records three values in registers that software can read: the faulting address, a status word and a formatted page-table address. These registers then lock until software reads the fault address. A later fault therefore cannot overwrite the state of the first one.

Top module: `dxlate_unit`

## Requirements
- R1: The mode used for the permission checks is taken as follows. If `priv_code` is 1, it is `alt_mode` when `req_alt` is 1 and kernel when `req_alt` is 0. If `priv_code` is 0, it is `cur_mode`. Modes are encoded kernel=0, executive=1, supervisor=2, user=3, and mode m selects bit m of `tlb_rd_en` and `tlb_wr_en`.
- R2: A superpage access is a non-physical request with `sp_enable[1]`=1 and `req_va[42:41]`=2. It maps without the TLB. If VA bit 39 or bit 40 is 1, then `pa` equals the VA with `pa[43:40]` forced to 4'hF. Otherwise `pa` is the VA truncated to 40 bits.
- R3: A superpage access when `cur_mode` is not kernel gives fault code 1 (access violation) and the status flags write|acv.
- R4: On a TLB hit, `pa` is `{tlb_pfn, req_va[12:0]}`, truncated to 44 bits.
- R5: A write with the mode's write enable at 0 gives code 2 and the flags write|acv, plus fow when `tlb_fow` is 1. A permitted write with `tlb_fow`=1 gives code 2 and the flags write|fow.
- R6: A read with the mode's read enable at 0 gives code 1 and the flag acv, plus for when `tlb_for` is 1. A permitted read with `tlb_for`=1 gives code 2 and the flag for.
- R7: A TLB miss gives code 3, or code 4 when `req_ptable` is 1. The flags are miss, plus write when the request is a write.
- R8: The status word is `{opcode[5:0], reg[4:0], flags[5:0]}`. The flag bits are write=bit0, acv=bit1, for=bit2, fow=bit3, miss=bit4, bad address=bit5. The formatted address is `ptbase | (req_va[42:13] << 3)`.
- R9: A valid request with code 1 to 4 is captured one clock later, but only while unlocked, and the capture sets `fault_locked`. While locked, further faults leave the registers unchanged. A `fva_read` pulse clears the lock at the next clock.
- R10: If the physical result from the TLB has any bit at position 44 or above set, the code is 5 (machine check), and nothing is captured.
- R11: `uncached` is 1 exactly when the code is 0 and `pa[39]` or `pa[40]` is 1.
- R12: A physical-mode request gives `pa` = `req_va` zero-extended, with code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_va | input | 43 | Virtual address |
| req_write | input | 1 | 1 = store, 0 = load |
| req_phys | input | 1 | Physical-mode request |
| req_alt | input | 1 | Use alternate mode (privileged code only) |
| req_ptable | input | 1 | Request is a page-table access |
| req_opcode | input | 6 | Opcode recorded in the status word |
| req_reg | input | 5 | Register number recorded in the status word |
| cur_mode | input | 2 | Current mode |
| alt_mode | input | 2 | Alternate mode |
| priv_code | input | 1 | Request issued by privileged code |
| sp_enable | input | 2 | Superpage enables, bit 1 used |
| ptbase | input | 44 | Page-table base for the formatted address |
| tlb_hit | input | 1 | TLB lookup hit |
| tlb_pfn | input | 35 | Page frame number from the TLB |
| tlb_rd_en | input | 4 | Per-mode read enables |
| tlb_wr_en | input | 4 | Per-mode write enables |
| tlb_for | input | 1 | Fault-on-read bit |
| tlb_fow | input | 1 | Fault-on-write bit |
| fva_read | input | 1 | Software read of the fault address (unlock) |
| pa | output | 44 | Physical address |
| uncached | output | 1 | Physical address is uncacheable |
| fault_code | output | 3 | 0 none, 1 acv, 2 fault, 3 miss, 4 page-table miss, 5 machine check |
| fault_va | output | 43 | Captured fault address |
| fault_stat | output | 17 | Captured status word |
| fault_form | output | 44 | Captured formatted page-table address |
| fault_locked | output | 1 | Fault registers locked |

## Verification
The fault-address read that releases the lock and a new recoverable fault can arrive in the same cycle. The bench provokes this deliberately: while the lock holds, it drives a miss with a fresh address together with `fva_read`. It then expects the lock to drop at the next clock with the captured address still the old one. It also expects the next fault that follows to be captured. A second overlap is a permission fault on an address whose frame number also overflows the physical width. Here the bench expects the permission code, not machine check, and expects a capture.

// File: rtl/dxl_pkg.sv
package dxl_pkg;
    localparam int VA_W    = 43;
    localparam int PA_W    = 44;
    localparam int PG_BITS = 13;
    localparam int PFN_W   = 35;
    localparam int RAW_W   = PFN_W + PG_BITS;
    localparam int VPN_W   = VA_W - PG_BITS;
    localparam int STAT_W  = 17;
    localparam int SP_LO   = 40;

    typedef enum logic [2:0] {
        FLT_NONE  = 3'd0,
        FLT_ACV   = 3'd1,
        FLT_FAULT = 3'd2,
        FLT_NMISS = 3'd3,
        FLT_PMISS = 3'd4,
        FLT_MCHK  = 3'd5
    } fault_e;

    typedef enum logic [1:0] {
        MODE_KERN = 2'd0,
        MODE_EXEC = 2'd1,
        MODE_SUPV = 2'd2,
        MODE_USER = 2'd3
    } mode_e;

    localparam int FB_WR   = 0;
    localparam int FB_ACV  = 1;
    localparam int FB_FOR  = 2;
    localparam int FB_FOW  = 3;
    localparam int FB_MISS = 4;
    localparam int FB_BADV = 5;

    typedef struct packed {
        logic [PA_W-1:0] pa;
        fault_e          code;
        logic [5:0]      flags;
    } xlate_t;

    function automatic logic [PA_W-1:0] sp_map(input logic [VA_W-1:0] va);
        logic [PA_W-1:0] p;
        p = {{(PA_W-VA_W){1'b0}}, va};
        if (p[39] || p[40]) p[PA_W-1:SP_LO] = '1;
        else                p[PA_W-1:SP_LO] = '0;
        return p;
    endfunction
endpackage

// File: rtl/dxl_mode_sel.sv
module dxl_mode_sel
    import dxl_pkg::*;
(
    input  logic  priv_code,
    input  logic  req_alt,
    input  mode_e cur_mode,
    input  mode_e alt_mode,
    output mode_e eff_mode
);
    always_comb begin
        if (priv_code) eff_mode = req_alt ? alt_mode : MODE_KERN;
        else           eff_mode = cur_mode;
    end
endmodule

// File: rtl/dxl_xlate.sv
module dxl_xlate
    import dxl_pkg::*;
(
    input  logic [VA_W-1:0]  va,
    input  logic             wr,
    input  logic             phys,
    input  logic             ptable,
    input  mode_e            cur_mode,
    input  mode_e            eff_mode,
    input  logic [1:0]       sp_enable,
    input  logic             hit,
    input  logic [PFN_W-1:0] pfn,
    input  logic [3:0]       rd_en,
    input  logic [3:0]       wr_en,
    input  logic             f_or,
    input  logic             f_ow,
    output xlate_t           res
);
    logic [RAW_W-1:0] raw;
    logic             is_sp;

    assign raw   = {pfn, va[PG_BITS-1:0]};
    assign is_sp = sp_enable[1] && (va[VA_W-1:VA_W-2] == 2'b10);

    always_comb begin
        res.pa    = '0;
        res.code  = FLT_NONE;
        res.flags = '0;
        if (phys) begin
            res.pa = {{(PA_W-VA_W){1'b0}}, va};
        end else if (is_sp) begin
            res.pa = sp_map(va);
            if (cur_mode != MODE_KERN) begin
                res.code          = FLT_ACV;
                res.flags[FB_WR]  = wr;
                res.flags[FB_ACV] = 1'b1;
            end
        end else if (!hit) begin
            res.code           = ptable ? FLT_PMISS : FLT_NMISS;
            res.flags[FB_WR]   = wr;
            res.flags[FB_MISS] = 1'b1;
        end else begin
            res.pa = raw[PA_W-1:0];
            if (wr) begin
                res.flags[FB_WR] = 1'b1;
                if (!wr_en[eff_mode]) begin
                    res.code          = FLT_FAULT;
                    res.flags[FB_ACV] = 1'b1;
                    res.flags[FB_FOW] = f_ow;
                end else if (f_ow) begin
                    res.code          = FLT_FAULT;
                    res.flags[FB_FOW] = 1'b1;
                end
            end else begin
                if (!rd_en[eff_mode]) begin
                    res.code          = FLT_ACV;
                    res.flags[FB_ACV] = 1'b1;
                    res.flags[FB_FOR] = f_or;
                end else if (f_or) begin
                    res.code          = FLT_FAULT;
                    res.flags[FB_FOR] = 1'b1;
                end
            end
            if (res.code == FLT_NONE && raw[RAW_W-1:PA_W] != '0)
                res.code = FLT_MCHK;
        end
    end
endmodule

// File: rtl/dxl_fault_regs.sv
module dxl_fault_regs
    import dxl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap,
    input  logic              rd,
    input  logic [VA_W-1:0]   va_in,
    input  logic [STAT_W-1:0] stat_in,
    input  logic [PA_W-1:0]   form_in,
    output logic [VA_W-1:0]   va_q,
    output logic [STAT_W-1:0] stat_q,
    output logic [PA_W-1:0]   form_q,
    output logic              lock_q
);
    logic take;
    assign take = cap && !lock_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            va_q   <= '0;
            stat_q <= '0;
            form_q <= '0;
            lock_q <= 1'b0;
        end else begin
            if (take) begin
                va_q   <= va_in;
                stat_q <= stat_in;
                form_q <= form_in;
                lock_q <= 1'b1;
            end else if (rd) begin
                lock_q <= 1'b0;
            end
        end
    end

    p_lock_sets_r9: assert property (@(posedge clk) disable iff (rst)
        (cap && !lock_q) |=> lock_q);
    p_lock_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (lock_q && rd) |=> !lock_q);
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> ($stable(va_q) && $stable(stat_q) && $stable(form_q)));
endmodule

// File: rtl/dxlate_unit.sv
module dxlate_unit
    import dxl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_va,
    input  logic              req_write,
    input  logic              req_phys,
    input  logic              req_alt,
    input  logic              req_ptable,
    input  logic [5:0]        req_opcode,
    input  logic [4:0]        req_reg,
    input  logic [1:0]        cur_mode,
    input  logic [1:0]        alt_mode,
    input  logic              priv_code,
    input  logic [1:0]        sp_enable,
    input  logic [PA_W-1:0]   ptbase,
    input  logic              tlb_hit,
    input  logic [PFN_W-1:0]  tlb_pfn,
    input  logic [3:0]        tlb_rd_en,
    input  logic [3:0]        tlb_wr_en,
    input  logic              tlb_for,
    input  logic              tlb_fow,
    input  logic              fva_read,
    output logic [PA_W-1:0]   pa,
    output logic              uncached,
    output logic [2:0]        fault_code,
    output logic [VA_W-1:0]   fault_va,
    output logic [STAT_W-1:0] fault_stat,
    output logic [PA_W-1:0]   fault_form,
    output logic              fault_locked
);
    mode_e             eff_mode;
    xlate_t            res;
    logic              cap;
    logic [STAT_W-1:0] stat_w;
    logic [PA_W-1:0]   form_w;

    dxl_mode_sel u_mode (
        .priv_code (priv_code),
        .req_alt   (req_alt),
        .cur_mode  (mode_e'(cur_mode)),
        .alt_mode  (mode_e'(alt_mode)),
        .eff_mode  (eff_mode)
    );

    dxl_xlate u_xlate (
        .va        (req_va),
        .wr        (req_write),
        .phys      (req_phys),
        .ptable    (req_ptable),
        .cur_mode  (mode_e'(cur_mode)),
        .eff_mode  (eff_mode),
        .sp_enable (sp_enable),
        .hit       (tlb_hit),
        .pfn       (tlb_pfn),
        .rd_en     (tlb_rd_en),
        .wr_en     (tlb_wr_en),
        .f_or      (tlb_for),
        .f_ow      (tlb_fow),
        .res       (res)
    );

    assign stat_w = {req_opcode, req_reg, res.flags};
    assign form_w = ptbase | ({{(PA_W-VPN_W){1'b0}}, req_va[VA_W-1:PG_BITS]} << 3);
    assign cap    = req_valid && (res.code inside {FLT_ACV, FLT_FAULT, FLT_NMISS, FLT_PMISS});

    dxl_fault_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .cap     (cap),
        .rd      (fva_read),
        .va_in   (req_va),
        .stat_in (stat_w),
        .form_in (form_w),
        .va_q    (fault_va),
        .stat_q  (fault_stat),
        .form_q  (fault_form),
        .lock_q  (fault_locked)
    );

    assign pa         = res.pa;
    assign fault_code = res.code;
    assign uncached   = (res.code == FLT_NONE) && (res.pa[39] || res.pa[40]);

    p_mchk_no_capture_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && fault_code == 3'd5 && !fault_locked && !fva_read) |=> !fault_locked);

    always_comb begin
        if (!req_phys && sp_enable[1] && req_va[VA_W-1:VA_W-2] == 2'b10 && fault_code == 3'd0)
            p_sp_upper_r2: assert (pa[PA_W-1:SP_LO] == 4'h0 || pa[PA_W-1:SP_LO] == 4'hF);
    end
endmodule

// File: tb/dxlate_unit_test.sv
module dxlate_unit_test;
    logic        clk = 0;
    logic        rst;
    logic        req_valid, req_write, req_phys, req_alt, req_ptable;
    logic [42:0] req_va;
    logic [5:0]  req_opcode;
    logic [4:0]  req_reg;
    logic [1:0]  cur_mode, alt_mode, sp_enable;
    logic        priv_code;
    logic [43:0] ptbase;
    logic        tlb_hit, tlb_for, tlb_fow, fva_read;
    logic [34:0] tlb_pfn;
    logic [3:0]  tlb_rd_en, tlb_wr_en;
    logic [43:0] pa;
    logic        uncached;
    logic [2:0]  fault_code;
    logic [42:0] fault_va;
    logic [16:0] fault_stat;
    logic [43:0] fault_form;
    logic        fault_locked;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dxlate_unit uut (.*);

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic idle();
        req_valid = 0; req_write = 0; req_phys = 0; req_alt = 0; req_ptable = 0;
        req_va = '0; req_opcode = '0; req_reg = '0; cur_mode = 0; alt_mode = 0;
        priv_code = 0; sp_enable = 0; tlb_hit = 1; tlb_pfn = '0;
        tlb_rd_en = 4'hF; tlb_wr_en = 4'hF; tlb_for = 0; tlb_fow = 0; fva_read = 0;
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic unlock();
        @(negedge clk); idle(); fva_read = 1; tick();
        @(negedge clk); fva_read = 0;
    endtask

    task automatic t_reset();
        chk("R9 reset lock", fault_locked, 0);
        chk("R9 reset va", fault_va, 0);
    endtask

    task automatic t_phys();
        logic [42:0] v;
        v = 43'h123_4567_89AB;
        @(negedge clk); idle(); req_valid = 1; req_phys = 1; req_va = v; tlb_hit = 0; #1;
        chk("R12 pa", pa, {1'b0, v});
        chk("R12 code", fault_code, 0);
        chk("R11 phys uncached", uncached, v[39] | v[40]);
    endtask

    task automatic t_super();
        logic [42:0] v;
        @(negedge clk); idle(); req_valid = 1; sp_enable = 2'b10; tlb_hit = 0;
        v = (43'd1 << 42) | 43'h1234_5678; req_va = v; #1;
        chk("R2 truncate", pa, 44'h00012345678);
        chk("R2 code", fault_code, 0);
        chk("R11 sp cached", uncached, 0);
        v = (43'd1 << 42) | (43'd1 << 39) | 43'hABC; req_va = v; #1;
        chk("R2 extend", pa, 44'hF8000000ABC);
        chk("R11 sp uncached", uncached, 1);
        sp_enable = 2'b01; #1;
        chk("R2 disabled goes to tlb", fault_code, 3);
        @(negedge clk); fva_read = 1; req_valid = 0; tick();
    endtask

    task automatic t_super_acv();
        logic [42:0] v;
        @(negedge clk); idle(); req_valid = 1; sp_enable = 2'b10; cur_mode = 3; req_write = 1;
        v = (43'd1 << 42) | 43'h5_0000; req_va = v; req_opcode = 6'h2A; req_reg = 5'h15;
        ptbase = 44'h800_0000_0000; #1;
        chk("R3 code", fault_code, 1);
        tick();
        chk("R3 captured", fault_locked, 1);
        chk("R8 stat layout", fault_stat, {6'h2A, 5'h15, 6'b000011});
        chk("R8 form", fault_form, 44'h800_0000_0000 | ({14'd0, v[42:13]} << 3));
        chk("R8 va", fault_va, v);
        unlock();
    endtask

    task automatic t_hit();
        @(negedge clk); idle(); req_valid = 1; tlb_pfn = 35'h12345; req_va = 43'h7_1ABC; #1;
        chk("R4 pa", pa, (44'h12345 << 13) | 44'h1ABC);
        chk("R4 code", fault_code, 0);
        chk("R11 hit cached", uncached, 0);
        tlb_pfn = 35'h4000000; #1;
        chk("R11 hit uncached", uncached, 1);
    endtask

    task automatic t_write();
        @(negedge clk); idle(); req_valid = 1; req_write = 1; tlb_wr_en = 4'b1110; tlb_fow = 1;
        req_va = 43'h100; #1;
        chk("R5 acv code", fault_code, 2);
        tick();
        chk("R5 acv flags", fault_stat[5:0], 6'b001011);
        unlock();
        req_valid = 1; req_write = 1; tlb_wr_en = 4'hF; tlb_fow = 1; req_va = 43'h200; #1;
        chk("R5 fow code", fault_code, 2);
        tick();
        chk("R5 fow flags", fault_stat[5:0], 6'b001001);
        unlock();
    endtask

    task automatic t_read();
        @(negedge clk); idle(); req_valid = 1; cur_mode = 3; tlb_rd_en = 4'b0111; tlb_for = 1;
        req_va = 43'h300; #1;
        chk("R6 acv code", fault_code, 1);
        tick();
        chk("R6 acv flags", fault_stat[5:0], 6'b000110);
        unlock();
        req_valid = 1; cur_mode = 3; tlb_rd_en = 4'hF; tlb_for = 1; req_va = 43'h400; #1;
        chk("R6 for code", fault_code, 2);
        tick();
        chk("R6 for flags", fault_stat[5:0], 6'b000100);
        unlock();
    endtask

    task automatic t_miss();
        @(negedge clk); idle(); req_valid = 1; tlb_hit = 0; req_va = 43'h500; #1;
        chk("R7 native miss", fault_code, 3);
        tick();
        chk("R7 miss flags", fault_stat[5:0], 6'b010000);
        unlock();
        req_valid = 1; tlb_hit = 0; req_ptable = 1; req_write = 1; req_va = 43'h600; #1;
        chk("R7 pt miss", fault_code, 4);
        tick();
        chk("R7 pt miss flags", fault_stat[5:0], 6'b010001);
        unlock();
    endtask

    task automatic t_mode();
        @(negedge clk); idle(); req_valid = 1; priv_code = 1; req_alt = 1; alt_mode = 3;
        tlb_rd_en = 4'b0001; req_va = 43'h700; #1;
        chk("R1 alt mode used", fault_code, 1);
        req_alt = 0; cur_mode = 3; #1;
        chk("R1 kernel when no alt", fault_code, 0);
        priv_code = 0; #1;
        chk("R1 current mode", fault_code, 1);
        @(negedge clk); idle(); fva_read = 1; tick();
        @(negedge clk); fva_read = 0;
    endtask

    task automatic t_mchk();
        @(negedge clk); idle(); req_valid = 1; tlb_pfn = 35'h4_0000_0000; req_va = 43'h10; #1;
        chk("R10 code", fault_code, 5);
        chk("R11 no uncached on fault", uncached, 0);
        tick();
        chk("R10 no capture", fault_locked, 0);
        @(negedge clk); tlb_rd_en = 4'b0000; #1;
        chk("R10 permission first", fault_code, 1);
        tick();
        chk("R10 permission captured", fault_locked, 1);
        unlock();
    endtask

    task automatic t_lock();
        @(negedge clk); idle(); req_valid = 1; tlb_hit = 0; req_va = 43'h1_1111; tick();
        chk("R9 first capture", fault_va, 43'h1_1111);
        @(negedge clk); req_va = 43'h2_2222; tick();
        chk("R9 locked hold", fault_va, 43'h1_1111);
        chk("R9 still locked", fault_locked, 1);
        @(negedge clk); req_va = 43'h3_3333; fva_read = 1; tick();
        chk("R9 read with fault unlocks", fault_locked, 0);
        chk("R9 read with fault no capture", fault_va, 43'h1_1111);
        @(negedge clk); fva_read = 0; req_va = 43'h4_4444; tick();
        chk("R9 next capture", fault_va, 43'h4_4444);
        unlock();
    endtask

    initial begin
        idle();
        rst = 1;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        #1;
        t_reset();
        t_phys();
        t_super();
        t_super_acv();
        t_hit();
        t_write();
        t_read();
        t_miss();
        t_mode();
        t_mchk();
        t_lock();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule